// File: doc/BRIEF.md
# Emulation Memory Map Decoder

This block sits between an emulation processor's address bus and two possible homes for each bus cycle. One home is internal emulation memory, built as a set of relocatable 8 KB blocks. The other is the external target board. Each cycle the decoder looks at the 20-bit address and decides where the cycle goes. When the cycle goes external, it drives the address buffer and data transceiver controls. When it stays inside, it picks the one internal block that answers, if there is one. Writes to a block marked read-only are blocked and leave a sticky mark.

The decoder holds two maps. The first is a route map that marks each 256-byte page as internal or external. The second is a placement table that gives the 8 KB frame each block occupies. The route map wins over the placement table: a page marked external goes to the target even when a block is placed there. An internal page with no block placed on it selects nothing, and a read there sees a floating bus. A control processor programs and reads back both maps through a small word-wide register port. The memory arrays themselves sit outside this block.

Top module: `emap_decoder`

## Requirements
- R1: After reset, every page routes internal, block i sits at frame i, no block is read-only, the violation flag is clear, and every cycle output is low.
- R2: The route map is read and written as words through register space 0 (cfg_addr[9:8]=00, word index cfg_addr[7:0]). Bit j of word k covers page 16k+j, which is byte addresses (16k+j)*256 up to (16k+j)*256+255. A bit value of 1 means external.
- R3: A cycle whose page is marked external asserts route_ext and enables no block, even when a block is placed at that address.
- R4: Block registers live in space 1 (cfg_addr[9:8]=01, block number cfg_addr[2:0]). Data bits [6:0] hold the frame, which is compared with address bits [19:13]. Bit 15 marks the block read-only. An internal cycle enables, in one-hot form on blk_en, the block whose frame matches.
- R5: When several blocks share a frame, only the lowest-numbered one is enabled.
- R6: An internal cycle whose frame holds no block leaves blk_en at zero and raises float_rd if the cycle is a read.
- R7: Buffer controls follow the cycle type:
  - External read: abuf_to_tgt=1, dbuf_en=1, dbuf_to_tgt=0.
  - External write: all three are 1.
  - Internal read or write: all three are 0.
- R8: A write that lands on a read-only block keeps mem_we low and sets the violation flag. Reads of that block are served normally, and writes to other blocks raise mem_we.
- R9: The violation flag is status bit 0 in space 2 (cfg_addr[9:8]=10). It stays set until a register write to space 2 with data bit 0 set. A violation in the same cycle as that clear leaves the flag set.
- R10: The decode is registered. A cycle presented with bus_valid at a clock edge shows its results, with cyc_valid high, during the following clock period. With bus_valid low, every cycle output is low.
- R11: cfg_rdata returns, combinationally, the addressed route map word, block register ({read-only, 8'b0, frame}) or status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_addr | input | 20 | Byte address of the cycle |
| bus_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register space [9:8] and index [7:0] |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| cyc_valid | output | 1 | Decoded cycle outputs are valid |
| route_ext | output | 1 | The cycle goes to the target |
| blk_en | output | 8 | One-hot internal block enable |
| mem_we | output | 1 | Write strobe to the enabled block |
| float_rd | output | 1 | Internal read with no block behind it |
| abuf_to_tgt | output | 1 | Address buffer drives the target |
| dbuf_en | output | 1 | Data transceiver enabled |
| dbuf_to_tgt | output | 1 | Transceiver direction: toward the target |
| wp_viol | output | 1 | Sticky write-protect violation flag |

## Verification
The bench targets these corners:
- Page edges around an external page (0x020FF, 0x02100, 0x021FF, 0x02200). A decoder that slices the wrong address bits for the route map would route one of these wrongly.
- An external page over a placed block. A design that let placement win would raise a block enable on a target cycle.
- Two blocks on the same frame, before and after one of them moves away. This exposes a wrong priority or a non-one-hot enable.
- A read-only block: writes to it are checked for a suppressed strobe and a raised flag. A clear is applied in the same cycle as a fresh violation, which catches a flag that clears when it should stay set.
- A read of an unplaced frame. A design that defaulted to block 0 would drive data where the bus should float.

// File: rtl/emap_pkg.sv
package emap_pkg;

   // register spaces selected by the two top bits of the config address
   typedef enum logic [1:0] {
      CFG_ROUTE = 2'b00,
      CFG_PLACE = 2'b01,
      CFG_STAT  = 2'b10,
      CFG_NONE  = 2'b11
   } cfg_space_e;

   // cycle classes that decide the buffer controls
   typedef enum logic [2:0] {
      XF_IDLE,
      XF_EXT_RD,
      XF_EXT_WR,
      XF_INT_RD,
      XF_INT_WR
   } xfer_e;

   typedef struct packed {
      logic abuf_to_tgt;
      logic dbuf_en;
      logic dbuf_to_tgt;
   } buf_ctl_t;

endpackage

// File: rtl/emap_route_map.sv
module emap_route_map #(
   parameter int PIDX_W = 12,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PIDX_W-$clog2(WORD_W)-1:0] wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PIDX_W-$clog2(WORD_W)-1:0] rd_idx,
   output logic [WORD_W-1:0] rd_data,
   input  logic [PIDX_W-1:0] page,
   output logic              is_ext
);
   localparam int BSEL_W = $clog2(WORD_W);
   localparam int WIDX_W = PIDX_W - BSEL_W;
   localparam int NWORD  = 2 ** WIDX_W;

   logic [WORD_W-1:0] map_q [NWORD];

   // every page starts internal (bit value 0)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < NWORD; w++) map_q[w] <= '0;
      end else if (wr_en) begin
         map_q[wr_idx] <= wr_data;
      end
   end

   logic [WORD_W-1:0] look_word;
   assign look_word = map_q[page[PIDX_W-1:BSEL_W]];
   assign is_ext    = look_word[page[BSEL_W-1:0]];
   assign rd_data   = map_q[rd_idx];

endmodule

// File: rtl/emap_block_place.sv
module emap_block_place #(
   parameter int FRAME_W = 7,
   parameter int NUM_BLK = 8,
   parameter int WORD_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [$clog2(NUM_BLK)-1:0] wr_idx,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [$clog2(NUM_BLK)-1:0] rd_idx,
   output logic [WORD_W-1:0]  rd_data,
   input  logic [FRAME_W-1:0] frame,
   output logic [NUM_BLK-1:0] sel_onehot,
   output logic               sel_ro
);
   localparam int PAD_W = WORD_W - FRAME_W - 1;

   logic [FRAME_W-1:0] base_q [NUM_BLK];
   logic [NUM_BLK-1:0] ro_q;
   logic [NUM_BLK-1:0] hit;

   // contiguous placement from address zero after reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BLK; b++) base_q[b] <= FRAME_W'(b);
         ro_q <= '0;
      end else if (wr_en) begin
         base_q[wr_idx] <= wr_data[FRAME_W-1:0];
         ro_q[wr_idx]   <= wr_data[WORD_W-1];
      end
   end

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_cmp
      assign hit[b] = (base_q[b] == frame);
   end

   // isolate the lowest set bit: lowest-numbered block wins
   assign sel_onehot = hit & (~hit + NUM_BLK'(1));
   assign sel_ro     = |(sel_onehot & ro_q);

   if (PAD_W > 0) begin : g_pad
      assign rd_data = {ro_q[rd_idx], {PAD_W{1'b0}}, base_q[rd_idx]};
      logic unused_pad;
      assign unused_pad = ^wr_data[WORD_W-2:FRAME_W];
   end else begin : g_nopad
      assign rd_data = {ro_q[rd_idx], base_q[rd_idx]};
   end

endmodule

// File: rtl/emap_dir_ctl.sv
module emap_dir_ctl
   import emap_pkg::*;
#(
   parameter int NUM_BLK = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid,
   input  logic               wr,
   input  logic               ext,
   input  logic [NUM_BLK-1:0] sel,
   input  logic               sel_ro,
   output logic               cyc_valid,
   output logic               route_ext,
   output logic [NUM_BLK-1:0] blk_en,
   output logic               mem_we,
   output logic               float_rd,
   output buf_ctl_t           bufs,
   output logic               viol
);
   xfer_e    kind;
   buf_ctl_t bufs_d;
   logic     any_blk;

   assign any_blk = |sel;

   always_comb begin
      if (!valid)   kind = XF_IDLE;
      else if (ext) kind = wr ? XF_EXT_WR : XF_EXT_RD;
      else          kind = wr ? XF_INT_WR : XF_INT_RD;
   end

   always_comb begin
      bufs_d = '0;
      case (kind)
         XF_EXT_RD: bufs_d = '{abuf_to_tgt: 1'b1, dbuf_en: 1'b1, dbuf_to_tgt: 1'b0};
         XF_EXT_WR: bufs_d = '{abuf_to_tgt: 1'b1, dbuf_en: 1'b1, dbuf_to_tgt: 1'b1};
         default:   bufs_d = '0;
      endcase
   end

   assign viol = (kind == XF_INT_WR) && any_blk && sel_ro;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_valid <= 1'b0;
         route_ext <= 1'b0;
         blk_en    <= '0;
         mem_we    <= 1'b0;
         float_rd  <= 1'b0;
         bufs      <= '0;
      end else begin
         cyc_valid <= (kind != XF_IDLE);
         route_ext <= (kind == XF_EXT_RD) || (kind == XF_EXT_WR);
         blk_en    <= (kind == XF_INT_RD || kind == XF_INT_WR) ? sel : '0;
         mem_we    <= (kind == XF_INT_WR) && any_blk && !sel_ro;
         float_rd  <= (kind == XF_INT_RD) && !any_blk;
         bufs      <= bufs_d;
      end
   end

endmodule

// File: rtl/emap_decoder.sv
module emap_decoder
   import emap_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int PAGE_W     = 8,
   parameter int BLK_W      = 13,
   parameter int NUM_BLK    = 8,
   parameter int MAP_WORD_W = 16,
   parameter int CFG_AW     = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_write,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [MAP_WORD_W-1:0] cfg_wdata,
   output logic [MAP_WORD_W-1:0] cfg_rdata,
   output logic                  cyc_valid,
   output logic                  route_ext,
   output logic [NUM_BLK-1:0]    blk_en,
   output logic                  mem_we,
   output logic                  float_rd,
   output logic                  abuf_to_tgt,
   output logic                  dbuf_en,
   output logic                  dbuf_to_tgt,
   output logic                  wp_viol
);
   localparam int PIDX_W  = ADDR_W - PAGE_W;
   localparam int BSEL_W  = $clog2(MAP_WORD_W);
   localparam int WIDX_W  = PIDX_W - BSEL_W;
   localparam int FRAME_W = ADDR_W - BLK_W;
   localparam int BIDX_W  = $clog2(NUM_BLK);

   // elaboration-time parameter checks
   if (BLK_W < PAGE_W || ADDR_W <= BLK_W) begin : g_bad_geom
      $error("emap_decoder: need PAGE_W <= BLK_W < ADDR_W");
   end
   if (MAP_WORD_W != 2 ** BSEL_W) begin : g_bad_word
      $error("emap_decoder: MAP_WORD_W must be a power of two");
   end
   if (MAP_WORD_W < FRAME_W + 1) begin : g_bad_wide
      $error("emap_decoder: register word too narrow for a frame and flag");
   end
   if (NUM_BLK < 2 || NUM_BLK > 2 ** FRAME_W) begin : g_bad_nblk
      $error("emap_decoder: NUM_BLK out of range");
   end
   if (CFG_AW != WIDX_W + 2 || WIDX_W < BIDX_W) begin : g_bad_cfg
      $error("emap_decoder: CFG_AW must equal route word index width + 2");
   end

   cfg_space_e            space;
   logic [WIDX_W-1:0]     cfg_idx;
   logic                  map_wr, blk_wr, stat_clr;
   logic [MAP_WORD_W-1:0] map_rd, blk_rd;
   logic                  page_ext;
   logic [NUM_BLK-1:0]    sel;
   logic                  sel_ro;
   logic                  viol_now;
   buf_ctl_t              bufs;

   assign space    = cfg_space_e'(cfg_addr[CFG_AW-1 -: 2]);
   assign cfg_idx  = cfg_addr[WIDX_W-1:0];
   assign map_wr   = cfg_we && (space == CFG_ROUTE);
   assign blk_wr   = cfg_we && (space == CFG_PLACE);
   assign stat_clr = cfg_we && (space == CFG_STAT) && cfg_wdata[0];

   emap_route_map #(.PIDX_W(PIDX_W), .WORD_W(MAP_WORD_W)) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (map_wr),
      .wr_idx  (cfg_idx),
      .wr_data (cfg_wdata),
      .rd_idx  (cfg_idx),
      .rd_data (map_rd),
      .page    (bus_addr[ADDR_W-1:PAGE_W]),
      .is_ext  (page_ext)
   );

   emap_block_place #(.FRAME_W(FRAME_W), .NUM_BLK(NUM_BLK), .WORD_W(MAP_WORD_W)) u_place (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (blk_wr),
      .wr_idx     (cfg_idx[BIDX_W-1:0]),
      .wr_data    (cfg_wdata),
      .rd_idx     (cfg_idx[BIDX_W-1:0]),
      .rd_data    (blk_rd),
      .frame      (bus_addr[ADDR_W-1:BLK_W]),
      .sel_onehot (sel),
      .sel_ro     (sel_ro)
   );

   emap_dir_ctl #(.NUM_BLK(NUM_BLK)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (bus_valid),
      .wr        (bus_write),
      .ext       (page_ext),
      .sel       (sel),
      .sel_ro    (sel_ro),
      .cyc_valid (cyc_valid),
      .route_ext (route_ext),
      .blk_en    (blk_en),
      .mem_we    (mem_we),
      .float_rd  (float_rd),
      .bufs      (bufs),
      .viol      (viol_now)
   );

   assign abuf_to_tgt = bufs.abuf_to_tgt;
   assign dbuf_en     = bufs.dbuf_en;
   assign dbuf_to_tgt = bufs.dbuf_to_tgt;

   // sticky flag: a fresh violation outranks a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) wp_viol <= 1'b0;
      else        wp_viol <= (wp_viol && !stat_clr) || viol_now;
   end

   always_comb begin
      case (space)
         CFG_ROUTE: cfg_rdata = map_rd;
         CFG_PLACE: cfg_rdata = blk_rd;
         CFG_STAT:  cfg_rdata = {{(MAP_WORD_W-1){1'b0}}, wp_viol};
         default:   cfg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/emap_decoder_chk.sv
module emap_decoder_chk #(
   parameter int NUM_BLK    = 8,
   parameter int MAP_WORD_W = 16,
   parameter int CFG_AW     = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic [CFG_AW-1:0]     cfg_addr,
   input logic [MAP_WORD_W-1:0] cfg_wdata,
   input logic                  cyc_valid,
   input logic                  route_ext,
   input logic [NUM_BLK-1:0]    blk_en,
   input logic                  mem_we,
   input logic                  float_rd,
   input logic                  abuf_to_tgt,
   input logic                  dbuf_en,
   input logic                  dbuf_to_tgt,
   input logic                  wp_viol
);
   logic clr_req;
   assign clr_req = cfg_we && (cfg_addr[CFG_AW-1 -: 2] == 2'b10) && cfg_wdata[0];

   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(blk_en));

   p_lowest_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(blk_en) <= 1);

   p_ext_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      route_ext |-> (blk_en == '0) && !mem_we && !float_rd);

   p_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      float_rd |-> cyc_valid && (blk_en == '0) && !route_ext);

   p_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> (abuf_to_tgt == route_ext) && (dbuf_en == route_ext));

   p_dirsafe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dbuf_to_tgt |-> dbuf_en);

   p_we_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (blk_en != '0));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_viol && !clr_req) |=> wp_viol);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_valid |-> !route_ext && (blk_en == '0) && !mem_we && !float_rd
                     && !abuf_to_tgt && !dbuf_en);

endmodule

bind emap_decoder emap_decoder_chk #(
   .NUM_BLK(NUM_BLK), .MAP_WORD_W(MAP_WORD_W), .CFG_AW(CFG_AW)
) u_chk (.*);

// File: tb/tb_emap_decoder.sv
`timescale 1ns/1ps
module tb_emap_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_write = 1'b0;
   logic        cfg_we = 1'b0;
   logic [9:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        cyc_valid, route_ext, mem_we, float_rd;
   logic [7:0]  blk_en;
   logic        abuf_to_tgt, dbuf_en, dbuf_to_tgt, wp_viol;

   always #4 clk = ~clk;

   emap_decoder dut (.*);

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   typedef struct {
      logic       ext;
      logic [7:0] en;
      logic       we;
      logic       flt;
      logic       abuf;
      logic       den;
      logic       dtt;
      logic       flag;
      string      req;
   } exp_t;

   exp_t q[$];

   // independent reference state
   bit         m_ext [4096];
   logic [6:0] m_base [8];
   bit         m_ro [8];
   bit         m_flag = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic exp_t predict(input logic [19:0] a, input logic w, input string req);
      exp_t e;
      bit   ro = 1'b0;
      e.ext = m_ext[a[19:8]];
      e.en  = '0;
      if (!e.ext) begin
         for (int b = 7; b >= 0; b--) begin
            if (m_base[b] == a[19:13]) begin
               e.en = 8'(1 << b);
               ro   = m_ro[b];
            end
         end
      end
      e.flt  = !e.ext && !w && (e.en == 0);
      e.we   = !e.ext && w && (e.en != 0) && !ro;
      if (!e.ext && w && (e.en != 0) && ro) m_flag = 1'b1;
      e.abuf = e.ext;
      e.den  = e.ext;
      e.dtt  = e.ext && w;
      e.flag = m_flag;
      e.req  = req;
      return e;
   endfunction

   task automatic bus_op(input logic [19:0] a, input logic w, input string req);
      @(negedge clk);
      q.push_back(predict(a, w, req));
      bus_valid = 1'b1; bus_addr = a; bus_write = w;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic cfg_wr(input logic [1:0] sp, input logic [7:0] idx, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {sp, idx}; cfg_wdata = d;
      if (sp == 2'd0) for (int j = 0; j < 16; j++) m_ext[idx*16+j] = d[j];
      if (sp == 2'd1) begin m_base[idx[2:0]] = d[6:0]; m_ro[idx[2:0]] = d[15]; end
      if (sp == 2'd2 && d[0]) m_flag = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [1:0] sp, input logic [7:0] idx,
                         input logic [15:0] exp, input string req);
      @(negedge clk);
      cfg_addr = {sp, idx};
      #1;
      chk(cfg_rdata == exp, req, "cfg_rdata", cfg_rdata, exp);
   endtask

   // monitor: pops one expected item per decoded cycle
   always @(posedge clk) begin
      #1;
      if (rst_n && cyc_valid === 1'b1) begin
         if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected cyc_valid", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(route_ext == e.ext, e.req, "route_ext", route_ext, e.ext);
            chk(blk_en == e.en, e.req, "blk_en", blk_en, e.en);
            chk(mem_we == e.we, e.req, "mem_we", mem_we, e.we);
            chk(float_rd == e.flt, e.req, "float_rd", float_rd, e.flt);
            chk({abuf_to_tgt, dbuf_en, dbuf_to_tgt} == {e.abuf, e.den, e.dtt}, "R7",
                "buffer controls", {abuf_to_tgt, dbuf_en, dbuf_to_tgt}, {e.abuf, e.den, e.dtt});
            chk(wp_viol == e.flag, e.req, "wp_viol", wp_viol, e.flag);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", "run did not finish", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4096; i++) m_ext[i] = 1'b0;
      for (int b = 0; b < 8; b++) begin m_base[b] = 7'(b); m_ro[b] = 1'b0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state
      #1;
      chk({cyc_valid, route_ext, blk_en, mem_we, float_rd, abuf_to_tgt, dbuf_en, dbuf_to_tgt, wp_viol} == '0,
          "R1", "idle outputs after reset",
          {cyc_valid, route_ext, blk_en, mem_we, float_rd, abuf_to_tgt, dbuf_en, dbuf_to_tgt, wp_viol}, 0);
      cfg_rd(2'd1, 8'd3, 16'h0003, "R1");
      cfg_rd(2'd1, 8'd7, 16'h0007, "R1");
      cfg_rd(2'd0, 8'd255, 16'h0000, "R1");
      cfg_rd(2'd2, 8'd0, 16'h0000, "R1");

      // R4 / R6: default contiguous placement
      bus_op(20'h00000, 1'b0, "R4");
      bus_op(20'h0E123, 1'b0, "R4");
      bus_op(20'h10000, 1'b0, "R6");
      bus_op(20'h10000, 1'b1, "R6");
      bus_op(20'h02000, 1'b1, "R8");

      // R2 / R3 / R7: page 0x021 external
      cfg_wr(2'd0, 8'd2, 16'h0002);
      cfg_rd(2'd0, 8'd2, 16'h0002, "R11");
      bus_op(20'h02100, 1'b0, "R2");
      bus_op(20'h021FF, 1'b1, "R7");
      bus_op(20'h020FF, 1'b0, "R2");
      bus_op(20'h02200, 1'b0, "R2");

      // R8: relocate block 5 to top frame, read-only
      cfg_wr(2'd1, 8'd5, 16'h807F);
      cfg_rd(2'd1, 8'd5, 16'h807F, "R11");
      bus_op(20'hFFFFF, 1'b0, "R8");
      bus_op(20'hFE010, 1'b1, "R8");
      cfg_rd(2'd2, 8'd0, 16'h0001, "R9");
      bus_op(20'h00000, 1'b0, "R9");
      cfg_wr(2'd2, 8'd0, 16'h0001);
      cfg_rd(2'd2, 8'd0, 16'h0000, "R9");

      // R5: overlap on frame 1
      cfg_wr(2'd1, 8'd6, 16'h0001);
      bus_op(20'h02000, 1'b0, "R5");
      cfg_wr(2'd1, 8'd1, 16'h0040);
      bus_op(20'h02000, 1'b0, "R5");
      bus_op(20'h80000, 1'b1, "R4");

      // R3: external page over a placed block
      cfg_wr(2'd0, 8'h80, 16'hFFFF);
      bus_op(20'h80000, 1'b0, "R3");
      bus_op(20'h80010, 1'b1, "R3");
      bus_op(20'h81000, 1'b0, "R4");

      // R9: violation in the same cycle as a clear keeps the flag
      bus_op(20'hFE000, 1'b1, "R8");
      @(negedge clk);
      q.push_back(predict(20'hFE000, 1'b1, "R9"));
      bus_valid = 1'b1; bus_addr = 20'hFE000; bus_write = 1'b1;
      cfg_we = 1'b1; cfg_addr = {2'd2, 8'd0}; cfg_wdata = 16'h0001;
      @(negedge clk);
      bus_valid = 1'b0; cfg_we = 1'b0;
      cfg_rd(2'd2, 8'd0, 16'h0001, "R9");
      cfg_wr(2'd2, 8'd0, 16'h0000);
      cfg_rd(2'd2, 8'd0, 16'h0001, "R9");
      cfg_wr(2'd2, 8'd0, 16'h0001);
      cfg_rd(2'd2, 8'd0, 16'h0000, "R9");

      // R10: idle when nothing presented
      repeat (2) @(negedge clk);
      chk(cyc_valid == 1'b0 && blk_en == 0 && !route_ext, "R10", "idle outputs",
          {cyc_valid, blk_en, route_ext}, 0);
      chk(q.size() == 0, "R10", "pending expected cycles", q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule